// File: doc/BRIEF.md
# Serial Interface Status Flag Controller

This block holds the four status flags of an asynchronous serial port: transmit holding register empty, transmission finished, receive holding register full, and receive line idle. The transmit and receive datapaths report their events to it as one-cycle strobes. It also watches the receive input, sampled once per bit time, and counts runs of ones to spot an idle line. Bus accesses reach it as three strobes: status read, data read and data write.

Every flag is set by its hardware event. Software clears a flag in two steps. First it reads the status while the flag is set, which arms that flag. Then it accesses the data register. A data write clears the armed transmit flags and a data read clears the armed receive flags. The newest status read decides which flags are armed. After the idle flag is cleared, it cannot set again until a complete frame has been received. While the receiver is in wakeup mode, no idle run sets the flag. When transmit-complete is set and cleared in the same cycle, it ends up clear.

All flag updates appear one clock after the edge that samples the causing strobe.

Top module: `sci_flag_ctrl`

## Requirements
- R1: Out of reset, tdre_o, tc_o and tx_line_idle_o are 1, and rdrf_o and idle_o are 0.
- R2: A tx_load_i strobe sets tdre_o on the next cycle. tdre_o clears after a status read that saw it set, followed by a data write.
- R3: tc_o is 0 in the cycle after any cycle with tx_busy_i high. When tdre_o is 1 and tx_busy_i is low, tc_o becomes 1 on the next cycle. tx_line_idle_o always equals tc_o.
- R4: tc_o clears on a data write armed by an earlier status read that saw it set, or on a tx_queue_i strobe. When its set condition and a clear fall in the same cycle, tc_o is 0 afterwards.
- R5: An rx_xfer_i strobe sets rdrf_o. An armed data read clears it. When rx_xfer_i coincides with that clearing data read, rdrf_o stays 1.
- R6: With frame9_i=0, idle_o sets after the 10th consecutive rx_bit_i=1 strobe; with frame9_i=1, after the 11th. Any strobe with rx_bit_i=0 restarts the run.
- R7: Once idle_o has been cleared, it stays 0 through any idle run until an rx_xfer_i strobe has occurred. idle_o clears on an armed data read.
- R8: While rx_wake_i is 1, a completed idle run does not set idle_o.
- R9: Arming follows the most recent status read only. A flag that was 0 at that read is not cleared by the following data access.
- R10: A data write clears only tdre_o and tc_o, and a data read clears only rdrf_o and idle_o. Arming of the other class survives the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_load_i | input | 1 | Byte moved from transmit holding register into shifter |
| tx_queue_i | input | 1 | Data, preamble or break queued for sending |
| tx_busy_i | input | 1 | A character is being shifted out |
| rx_xfer_i | input | 1 | Received frame moved into the receive holding register |
| rx_bit_stb_i | input | 1 | One strobe per received bit time |
| rx_bit_i | input | 1 | Sampled receive line value, valid with the strobe |
| frame9_i | input | 1 | 1 selects the longer frame (11-bit idle threshold) |
| rx_wake_i | input | 1 | Receiver wakeup mode; suppresses idle setting |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register low byte read strobe |
| data_wr_i | input | 1 | Data register low byte write strobe |
| tdre_o | output | 1 | Transmit holding register empty |
| tc_o | output | 1 | Transmission complete |
| rdrf_o | output | 1 | Receive holding register full |
| idle_o | output | 1 | Receive line idle |
| tx_line_idle_o | output | 1 | Forces the transmit line to its idle high level |

## Verification
The main collisions are between a hardware set and a software clear of the same flag in one cycle. For transmit-complete, tdre_o is brought high with the transmitter not busy, and tx_queue_i is pulsed in the very next cycle, when the set condition first holds. The expected result is 0. For receive-full, rx_xfer_i is driven together with an armed data read, and the flag must stay 1. A cycle-accurate behavioural model in the bench judges these and all other cycles: a status read in the same cycle as a data access, and a run of idle bits that completes while a clear is pending.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;

    localparam int FLAG_N = 4;

    typedef enum int {
        F_TDRE = 0,
        F_TC   = 1,
        F_RDRF = 2,
        F_IDLE = 3
    } flag_idx_e;

    // Flags cleared by a data write and by a data read, respectively.
    localparam logic [FLAG_N-1:0] WR_CLR_MASK = 4'b0011;
    localparam logic [FLAG_N-1:0] RD_CLR_MASK = 4'b1100;

    typedef struct packed {
        logic tdre;
        logic tc;
        logic rdrf;
        logic idle;
        logic idle_en;
    } flag_state_t;

endpackage

// File: rtl/sci_clr_arm.sv
module sci_clr_arm #(
    parameter int              N       = 4,
    parameter logic [N-1:0]    WR_MASK = '0,
    parameter logic [N-1:0]    RD_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stat_rd_i,
    input  logic         data_rd_i,
    input  logic         data_wr_i,
    input  logic [N-1:0] seen_i,
    output logic [N-1:0] clr_o
);

    logic [N-1:0] arm_d, arm_q;
    logic [N-1:0] used;

    always_comb begin
        used  = '0;
        if (data_wr_i) used = used | WR_MASK;
        if (data_rd_i) used = used | RD_MASK;
        clr_o = arm_q & used;
        // A status read re-captures the set flags; otherwise consumed arms drop.
        arm_d = stat_rd_i ? seen_i : (arm_q & ~used);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= '0;
        else        arm_q <= arm_d;
    end

    AST_WR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && !stat_rd_i) |=> ((arm_q & WR_MASK) == '0)); // R10

    AST_RD_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_i && !stat_rd_i) |=> ((arm_q & RD_MASK) == '0)); // R10

    AST_ARM_FROM_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i |=> ((arm_q & ~$past(seen_i)) == '0)); // R9

endmodule

// File: rtl/sci_idle_det.sv
module sci_idle_det #(
    parameter int SHORT_RUN = 10,
    parameter int LONG_RUN  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb_i,
    input  logic bit_i,
    input  logic long_i,
    output logic reach_o
);

    localparam int CW = $clog2(LONG_RUN + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit   = long_i ? CW'(LONG_RUN) : CW'(SHORT_RUN);
        cnt_d   = cnt_q;
        reach_o = 1'b0;
        if (bit_stb_i) begin
            if (!bit_i) begin
                cnt_d = '0;
            end else if (cnt_q < limit) begin
                cnt_d   = cnt_q + 1'b1;
                reach_o = (cnt_q == limit - 1'b1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LONG_RUN)); // R6

    AST_ZERO_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb_i && !bit_i) |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/sci_flag_ctrl.sv
module sci_flag_ctrl
    import sci_flag_pkg::*;
#(
    parameter int SHORT_RUN = 10,
    parameter int LONG_RUN  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_load_i,
    input  logic tx_queue_i,
    input  logic tx_busy_i,
    input  logic rx_xfer_i,
    input  logic rx_bit_stb_i,
    input  logic rx_bit_i,
    input  logic frame9_i,
    input  logic rx_wake_i,
    input  logic stat_rd_i,
    input  logic data_rd_i,
    input  logic data_wr_i,
    output logic tdre_o,
    output logic tc_o,
    output logic rdrf_o,
    output logic idle_o,
    output logic tx_line_idle_o
);

    flag_state_t       st_d, st_q;
    logic [FLAG_N-1:0] seen;
    logic [FLAG_N-1:0] clr;
    logic              reach;

    always_comb begin
        seen         = '0;
        seen[F_TDRE] = st_q.tdre;
        seen[F_TC]   = st_q.tc;
        seen[F_RDRF] = st_q.rdrf;
        seen[F_IDLE] = st_q.idle;
    end

    sci_clr_arm #(
        .N       (FLAG_N),
        .WR_MASK (WR_CLR_MASK),
        .RD_MASK (RD_CLR_MASK)
    ) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd_i (stat_rd_i),
        .data_rd_i (data_rd_i),
        .data_wr_i (data_wr_i),
        .seen_i    (seen),
        .clr_o     (clr)
    );

    sci_idle_det #(
        .SHORT_RUN (SHORT_RUN),
        .LONG_RUN  (LONG_RUN)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb_i (rx_bit_stb_i),
        .bit_i     (rx_bit_i),
        .long_i    (frame9_i),
        .reach_o   (reach)
    );

    always_comb begin
        st_d = st_q;

        // Transmit holding register empty: hardware set wins over clear.
        if (clr[F_TDRE]) st_d.tdre = 1'b0;
        if (tx_load_i)   st_d.tdre = 1'b1;

        // Transmission complete: any clear wins over the set condition.
        if (tx_busy_i)      st_d.tc = 1'b0;
        else if (st_q.tdre) st_d.tc = 1'b1;
        if (clr[F_TC] || tx_queue_i) st_d.tc = 1'b0;

        // Receive holding register full: new frame wins over clear.
        if (clr[F_RDRF]) st_d.rdrf = 1'b0;
        if (rx_xfer_i)   st_d.rdrf = 1'b1;

        // Idle line: clearing disarms detection until a frame arrives.
        if (clr[F_IDLE]) begin
            st_d.idle    = 1'b0;
            st_d.idle_en = 1'b0;
        end
        if (rx_xfer_i) st_d.idle_en = 1'b1;
        if (reach && st_q.idle_en && !rx_wake_i) st_d.idle = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tdre    <= 1'b1;
            st_q.tc      <= 1'b1;
            st_q.rdrf    <= 1'b0;
            st_q.idle    <= 1'b0;
            st_q.idle_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tdre_o         = st_q.tdre;
    assign tc_o           = st_q.tc;
    assign rdrf_o         = st_q.rdrf;
    assign idle_o         = st_q.idle;
    assign tx_line_idle_o = st_q.tc;

    AST_TDRE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_i |=> tdre_o); // R2

    AST_TC_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy_i |=> !tc_o); // R3

    AST_TC_QUEUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_queue_i |=> !tc_o); // R4

    AST_RDRF_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_xfer_i |=> rdrf_o); // R5

    AST_IDLE_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wake_i && !idle_o) |=> !idle_o); // R8

    AST_IDLE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.idle_en && !idle_o) |=> !idle_o); // R7

endmodule

// File: tb/sci_flag_ctrl_tb.sv
`timescale 1ns/1ps
module sci_flag_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_load = 0, tx_queue = 0, tx_busy = 0, rx_xfer = 0;
    logic bit_stb = 0, bit_val = 0, frame9 = 0, rx_wake = 0;
    logic stat_rd = 0, data_rd = 0, data_wr = 0;
    logic tdre, tc, rdrf, idle, line_idle;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sci_flag_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .tx_load_i (tx_load), .tx_queue_i (tx_queue), .tx_busy_i (tx_busy),
        .rx_xfer_i (rx_xfer), .rx_bit_stb_i (bit_stb), .rx_bit_i (bit_val),
        .frame9_i (frame9), .rx_wake_i (rx_wake),
        .stat_rd_i (stat_rd), .data_rd_i (data_rd), .data_wr_i (data_wr),
        .tdre_o (tdre), .tc_o (tc), .rdrf_o (rdrf), .idle_o (idle),
        .tx_line_idle_o (line_idle)
    );

    // Behavioural reference model.
    bit       m_tdre, m_tc, m_rdrf, m_idle, m_may_idle;
    bit [3:0] m_seen;   // 0 tdre, 1 tc, 2 rdrf, 3 idle
    int       m_ones;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tdre = 1; m_tc = 1; m_rdrf = 0; m_idle = 0;
            m_may_idle = 1; m_seen = 0; m_ones = 0;
        end else begin
            int  goal;
            bit  hit;
            bit  n_tdre, n_tc, n_rdrf, n_idle, n_may;
            goal = frame9 ? 11 : 10;
            hit  = 0;
            if (bit_stb) begin
                if (bit_val == 0) m_ones = 0;
                else if (m_ones < goal) begin
                    m_ones = m_ones + 1;
                    hit = (m_ones == goal);
                end
            end
            n_tdre = (tx_load) ? 1 : ((data_wr && m_seen[0]) ? 0 : m_tdre);
            n_tc   = tx_busy ? 0 : (m_tdre ? 1 : m_tc);
            if ((data_wr && m_seen[1]) || tx_queue) n_tc = 0;
            n_rdrf = rx_xfer ? 1 : ((data_rd && m_seen[2]) ? 0 : m_rdrf);
            n_idle = m_idle;
            n_may  = m_may_idle;
            if (data_rd && m_seen[3]) begin n_idle = 0; n_may = 0; end
            if (rx_xfer) n_may = 1;
            if (hit && m_may_idle && !rx_wake) n_idle = 1;
            if (stat_rd) m_seen = {m_idle, m_rdrf, m_tc, m_tdre};
            else begin
                if (data_wr) m_seen[1:0] = 2'b00;
                if (data_rd) m_seen[3:2] = 2'b00;
            end
            m_tdre = n_tdre; m_tc = n_tc; m_rdrf = n_rdrf;
            m_idle = n_idle; m_may_idle = n_may;
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 tdre model", tdre, m_tdre);
            chk("R4 tc model", tc, m_tc);
            chk("R3 line idle model", line_idle, m_tc);
            chk("R5 rdrf model", rdrf, m_rdrf);
            chk("R6 idle model", idle, m_idle);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic strobe(input logic v);
        bit_stb = 1; bit_val = v; tick();
        bit_stb = 0; bit_val = 0; tick();
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) strobe(1'b1);
    endtask

    task automatic sread();
        stat_rd = 1; tick(); stat_rd = 0;
    endtask

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset values
        chk("R1 tdre", tdre, 1); chk("R1 tc", tc, 1);
        chk("R1 line", line_idle, 1);
        chk("R1 rdrf", rdrf, 0); chk("R1 idle", idle, 0);

        // R2 / R4 two-step clear of transmit flags
        sread();
        data_wr = 1; tick(); data_wr = 0;
        chk("R2 tdre cleared", tdre, 0);
        chk("R4 tc cleared", tc, 0);
        tx_busy = 1; tx_load = 1; tick(); tx_load = 0;
        chk("R2 tdre set by load", tdre, 1);
        tick(); tick();
        chk("R3 tc low while busy", tc, 0);
        tx_busy = 0; tick();
        chk("R3 tc set when idle", tc, 1);
        chk("R3 line follows tc", line_idle, 1);

        // R4 simultaneous set and clear
        sread();
        data_wr = 1; tick(); data_wr = 0;
        tx_load = 1; tick(); tx_load = 0;
        tx_queue = 1; tick(); tx_queue = 0;
        chk("R4 set+clear gives 0", tc, 0);
        tick();
        chk("R3 tc recovers", tc, 1);

        // R5 / R9 receive-full
        rx_xfer = 1; tick(); rx_xfer = 0;
        chk("R5 rdrf set", rdrf, 1);
        data_rd = 1; tick(); data_rd = 0;
        chk("R9 unarmed read keeps rdrf", rdrf, 1);
        sread();
        data_rd = 1; rx_xfer = 1; tick(); data_rd = 0; rx_xfer = 0;
        chk("R5 set wins over clear", rdrf, 1);
        sread();
        data_rd = 1; tick(); data_rd = 0;
        chk("R5 rdrf cleared", rdrf, 0);

        // R10 access classes
        rx_xfer = 1; tick(); rx_xfer = 0;
        sread();
        data_wr = 1; tick(); data_wr = 0;
        chk("R10 wr clears tdre", tdre, 0);
        chk("R10 wr clears tc", tc, 0);
        chk("R10 wr keeps rdrf", rdrf, 1);
        data_rd = 1; tick(); data_rd = 0;
        chk("R10 rd clears rdrf", rdrf, 0);
        chk("R10 rd keeps tdre", tdre, 0);
        tx_load = 1; tick(); tx_load = 0; tick();

        // R6 idle run, short frame
        frame9 = 0;
        ones(5); strobe(1'b0); ones(9);
        chk("R6 idle not after 9", idle, 0);
        ones(1);
        chk("R6 idle after 10", idle, 1);

        // R7 re-arm by frame
        sread();
        data_rd = 1; tick(); data_rd = 0;
        chk("R7 idle cleared", idle, 0);
        strobe(1'b0); ones(12);
        chk("R7 no idle without frame", idle, 0);
        rx_xfer = 1; tick(); rx_xfer = 0;
        frame9 = 1;
        strobe(1'b0); ones(10);
        chk("R6 long frame not after 10", idle, 0);
        ones(1);
        chk("R6 long frame after 11", idle, 1);

        // R8 wakeup suppression
        sread();
        data_rd = 1; tick(); data_rd = 0;
        rx_xfer = 1; tick(); rx_xfer = 0;
        rx_wake = 1;
        strobe(1'b0); ones(11);
        chk("R8 wake suppresses idle", idle, 0);
        rx_wake = 0;
        strobe(1'b0); ones(11);
        chk("R8 idle after wake off", idle, 1);

        tick(); tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule